// File: doc/BRIEF.md
# Memory access fault checker

This block sits beside a processor core's load/store and fetch path. It classifies each access the core issues into one of four outcomes: allowed, misaligned, access error (or store error for writes), and access exception. It also returns the address the access should continue with. The classification comes from a fixed map of protected address windows. Which windows apply depends on the kind of access and on one of three rule sets, chosen by the `RULE_SET` parameter (0, 1 or 2).

An access is described by four inputs:
- a 32-bit byte address;
- an alignment mask that gives the access size (0, 1, 3, 7 or 15 for 1, 2, 4, 8 or 16 bytes);
- an access kind;
- two control bits: a protected-region enable and a misalignment-fault mask.

The outputs are one-hot fault flags and the corrected address. Where the rule set requires it, the corrected address has the bits under the mask cleared. With `REGISTERED` set, the results appear one clock after `valid_i` together with `valid_o`. With `REGISTERED` clear, the path is purely combinational.

Top module: `mem_fault_check`

## Requirements
- R1: `fault_o` bit 0 means misaligned, bit 1 access error, bit 2 store error and bit 3 access exception. At most one bit is set. When several causes apply, the order of precedence is misaligned, then access error, then store error, then exception. All bits are low whenever `valid_o` is low.
- R2: Kind codes are 0 load, 1 store, 2 fetch and 3 reserved. A reserved access gives no flags and an unchanged address. An aligned access that matches no window gives no flags and an unchanged address. The address bits above bit 3 are never changed.
- R3: Rule set 1. A load, store or fetch with any address bit set under the mask raises bit 0, and the corrected address has those bits cleared. Window checks use the corrected address.
- R4: Rule set 1. Data accesses in 0xFEFF0600..0xFEFF7FFF or 0xFE800000..0xFEFEFFFF raise bit 1 for a load and bit 2 for a store.
- R5: Rule set 1. Data accesses in 0xFE000000..0xFE7FFFFF raise bit 3.
- R6: Rule set 1. A fetch in either R4 window raises bit 1. Otherwise it raises bit 3 for 0xFE004000..0xFE7FFFFF, and also for 0xFE000000..0xFE003FFF when `prot_en_i` is 0.
- R7: Rule set 0. Only data accesses with mask 7 are window-checked, against 0xFE800000..0xFEFFFFFF. A load there raises bit 1 and a store raises bit 2.
- R8: Rule set 0. A misaligned data access raises bit 1 unless `mis_mask_i` is 1. A fetch raises bit 1 if it is misaligned or lies in 0xFE800000..0xFEFFFFFF. Every non-reserved address is aligned down. Bit 0 is never raised.
- R9: Rule set 2. Data accesses are never aligned and never raise bit 0. They raise an error (bit 1 for a load, bit 2 for a store) in 0xFE800000..0xFEFEFFFF, and in 0xFEFF0000..0xFEFFFFFF when the mask is greater than 3.
- R10: Rule set 2. Data accesses raise bit 3 in 0xFE000000..0xFE3FFFFF and 0xFE408000..0xFE7FFFFF. They also raise bit 3 in 0xFE400000..0xFE407FFF when `prot_en_i` is 0.
- R11: Rule set 2. A fetch is always aligned down. It raises bit 1 in 0xFE800000..0xFEFFFFFF. Otherwise it raises bit 3 in 0xFE008000..0xFE7FFFFF, and also in 0xFE000000..0xFE007FFF when `prot_en_i` is 0.
- R12: With `REGISTERED`=1, the outputs for an access appear on the clock edge after `valid_i`, with `valid_o` high for exactly that cycle. Reset clears `valid_o` and `fault_o`. With `REGISTERED`=0, the outputs follow the inputs in the same cycle.
- R13: All window compares are unsigned and inclusive at both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Access present this cycle |
| addr_i | input | 32 | Byte address of the access |
| mask_i | input | 4 | Alignment mask (0, 1, 3, 7, 15) |
| kind_i | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| prot_en_i | input | 1 | Protected-region enable |
| mis_mask_i | input | 1 | Suppresses the misalignment error in rule set 0 |
| valid_o | output | 1 | Result strobe |
| addr_o | output | 32 | Corrected address |
| fault_o | output | 4 | One-hot fault flags |

## Verification
The block keeps no state across accesses. A wrong window bound or a wrong precedence therefore shows up only on an access near that bound, as a wrong flag on the very result strobe of that access. A stuck or misrouted output register shows up as `valid_o` or a result landing a cycle early or late relative to `valid_i`. The directed cases put accesses exactly on the first and last byte of each window and one byte outside it. They also pair misalignment with an error window to expose the precedence. Seeded random accesses concentrated in the 0xFE000000 page cover the rest of each map.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned MASK_W  = 4;
  localparam int unsigned FAULT_W = 4;

  localparam int unsigned FLT_MISAL = 0;
  localparam int unsigned FLT_ERR   = 1;
  localparam int unsigned FLT_STERR = 2;
  localparam int unsigned FLT_EXC   = 3;

  localparam int unsigned RULES_A = 0;
  localparam int unsigned RULES_B = 1;
  localparam int unsigned RULES_C = 2;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic exc;
    logic st_err;
    logic err;
    logic misal;
  } fault_raw_t;

  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] lo,
                                  input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [ADDR_W-1:0] align_dn(input logic [ADDR_W-1:0] a,
                                                 input logic [MASK_W-1:0] m);
    return a & ~{{(ADDR_W-MASK_W){1'b0}}, m};
  endfunction
endpackage

// File: rtl/mfc_prio_enc.sv
module mfc_prio_enc
  import mfc_pkg::*;
(
  input  fault_raw_t         raw_i,
  output logic [FAULT_W-1:0] onehot_o
);
  always_comb begin
    onehot_o = '0;
    if (raw_i.misal)       onehot_o[FLT_MISAL] = 1'b1;
    else if (raw_i.err)    onehot_o[FLT_ERR]   = 1'b1;
    else if (raw_i.st_err) onehot_o[FLT_STERR] = 1'b1;
    else if (raw_i.exc)    onehot_o[FLT_EXC]   = 1'b1;
  end
endmodule

// File: rtl/mfc_classify.sv
module mfc_classify
  import mfc_pkg::*;
#(
  parameter int unsigned RULE_SET = RULES_B
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [MASK_W-1:0]  mask_i,
  input  logic [1:0]         kind_i,
  input  logic               prot_en_i,
  input  logic               mis_mask_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [FAULT_W-1:0] fault_o
);
  acc_kind_e  kind;
  logic       is_data, is_fetch, is_load, mis;
  logic [ADDR_W-1:0] a_al;
  fault_raw_t raw;

  assign kind     = acc_kind_e'(kind_i);
  assign is_load  = (kind == KIND_LOAD);
  assign is_data  = (kind == KIND_LOAD) || (kind == KIND_STORE);
  assign is_fetch = (kind == KIND_FETCH);
  assign mis      = |(addr_i[MASK_W-1:0] & mask_i);
  assign a_al     = align_dn(addr_i, mask_i);

  generate
    if (RULE_SET == RULES_A) begin : g_rules_a
      logic w_big, unused_ok;
      assign w_big     = in_win(a_al, 32'hFE80_0000, 32'hFEFF_FFFF);
      assign unused_ok = prot_en_i;
      always_comb begin
        raw    = '0;
        addr_o = addr_i;
        if (is_data) begin
          addr_o     = a_al;
          raw.err    = (mis && !mis_mask_i) || (is_load && mask_i == 4'd7 && w_big);
          raw.st_err = !is_load && mask_i == 4'd7 && w_big;
        end else if (is_fetch) begin
          addr_o  = a_al;
          raw.err = mis || w_big;
        end
      end
    end else if (RULE_SET == RULES_B) begin : g_rules_b
      logic w_err, w_dexc, w_fexc, w_fprot, unused_ok;
      assign w_err     = in_win(a_al, 32'hFEFF_0600, 32'hFEFF_7FFF) ||
                         in_win(a_al, 32'hFE80_0000, 32'hFEFE_FFFF);
      assign w_dexc    = in_win(a_al, 32'hFE00_0000, 32'hFE7F_FFFF);
      assign w_fexc    = in_win(a_al, 32'hFE00_4000, 32'hFE7F_FFFF);
      assign w_fprot   = in_win(a_al, 32'hFE00_0000, 32'hFE00_3FFF);
      assign unused_ok = mis_mask_i;
      always_comb begin
        raw    = '0;
        addr_o = addr_i;
        if (is_data) begin
          addr_o     = a_al;
          raw.misal  = mis;
          raw.err    = is_load && w_err;
          raw.st_err = !is_load && w_err;
          raw.exc    = w_dexc;
        end else if (is_fetch) begin
          addr_o    = a_al;
          raw.misal = mis;
          raw.err   = w_err;
          raw.exc   = !w_err && (w_fexc || (!prot_en_i && w_fprot));
        end
      end
    end else begin : g_rules_c
      logic w_derr, w_dexc, w_ferr, w_fexc, w_fprot, unused_ok;
      // data side uses the raw address: no alignment in this rule set
      assign w_derr  = in_win(addr_i, 32'hFE80_0000, 32'hFEFE_FFFF) ||
                       (mask_i > 4'd3 && in_win(addr_i, 32'hFEFF_0000, 32'hFEFF_FFFF));
      assign w_dexc  = in_win(addr_i, 32'hFE00_0000, 32'hFE3F_FFFF) ||
                       in_win(addr_i, 32'hFE40_8000, 32'hFE7F_FFFF) ||
                       (!prot_en_i && in_win(addr_i, 32'hFE40_0000, 32'hFE40_7FFF));
      assign w_ferr  = in_win(a_al, 32'hFE80_0000, 32'hFEFF_FFFF);
      assign w_fexc  = in_win(a_al, 32'hFE00_8000, 32'hFE7F_FFFF);
      assign w_fprot = in_win(a_al, 32'hFE00_0000, 32'hFE00_7FFF);
      assign unused_ok = mis_mask_i ^ mis;
      always_comb begin
        raw    = '0;
        addr_o = addr_i;
        if (is_data) begin
          raw.err    = is_load && w_derr;
          raw.st_err = !is_load && w_derr;
          raw.exc    = w_dexc;
        end else if (is_fetch) begin
          addr_o  = a_al;
          raw.err = w_ferr;
          raw.exc = !w_ferr && (w_fexc || (!prot_en_i && w_fprot));
        end
      end
    end
  endgenerate

  mfc_prio_enc u_prio (
    .raw_i    (raw),
    .onehot_o (fault_o)
  );
endmodule

// File: rtl/mfc_out_stage.sv
module mfc_out_stage
  import mfc_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [FAULT_W-1:0] fault_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [FAULT_W-1:0] fault_o
);
  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o <= 1'b0;
          addr_o  <= '0;
          fault_o <= '0;
        end else begin
          valid_o <= valid_i;
          fault_o <= valid_i ? fault_i : '0;
          if (valid_i) addr_o <= addr_i;
        end
      end
    end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk_i ^ rst_ni;
      assign valid_o   = valid_i;
      assign addr_o    = addr_i;
      assign fault_o   = valid_i ? fault_i : '0;
    end
  endgenerate
endmodule

// File: rtl/mem_fault_check.sv
module mem_fault_check
  import mfc_pkg::*;
#(
  parameter int unsigned RULE_SET   = RULES_B,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] addr_i,
  input  logic [3:0]  mask_i,
  input  logic [1:0]  kind_i,
  input  logic        prot_en_i,
  input  logic        mis_mask_i,
  output logic        valid_o,
  output logic [31:0] addr_o,
  output logic [3:0]  fault_o
);
  logic [ADDR_W-1:0]  corr_addr;
  logic [FAULT_W-1:0] fault_c;

  mfc_classify #(.RULE_SET(RULE_SET)) u_classify (
    .addr_i     (addr_i),
    .mask_i     (mask_i),
    .kind_i     (kind_i),
    .prot_en_i  (prot_en_i),
    .mis_mask_i (mis_mask_i),
    .addr_o     (corr_addr),
    .fault_o    (fault_c)
  );

  mfc_out_stage #(.REGISTERED(REGISTERED)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .addr_i  (corr_addr),
    .fault_i (fault_c),
    .valid_o (valid_o),
    .addr_o  (addr_o),
    .fault_o (fault_o)
  );
endmodule

// File: rtl/mem_fault_check_chk.sv
module mem_fault_check_chk #(
  parameter int unsigned RULE_SET   = 1,
  parameter bit          REGISTERED = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] addr_i,
  input logic [3:0]  mask_i,
  input logic [1:0]  kind_i,
  input logic        valid_o,
  input logic [31:0] addr_o,
  input logic [3:0]  fault_o
);
  AST_FAULT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fault_o)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> fault_o == 4'd0); // R1

  generate
    if (RULE_SET == 0) begin : g_a
      AST_A_NO_MISAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o[0]); // R8
    end else if (RULE_SET == 2) begin : g_c
      AST_C_NO_MISAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o[0]); // R9
    end
    if (REGISTERED) begin : g_reg
      AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o); // R12
      AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o); // R12
      AST_HIGH_BITS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> addr_o[31:4] == $past(addr_i[31:4])); // R2
      AST_RSVD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && kind_i == 2'd3) |=> (fault_o == 4'd0 && addr_o == $past(addr_i))); // R2
      if (RULE_SET != 2) begin : g_align
        AST_ALIGN_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (valid_i && kind_i != 2'd3) |=> (addr_o[3:0] & $past(mask_i)) == 4'd0); // R3
      end
    end
  endgenerate
endmodule

bind mem_fault_check mem_fault_check_chk #(
  .RULE_SET   (RULE_SET),
  .REGISTERED (REGISTERED)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .addr_i  (addr_i),
  .mask_i  (mask_i),
  .kind_i  (kind_i),
  .valid_o (valid_o),
  .addr_o  (addr_o),
  .fault_o (fault_o)
);

// File: tb/mem_fault_check_tb_top.sv
module mem_fault_check_tb_top;
  localparam time CLK_HALF = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  mask = '0;
  logic [1:0]  kind = '0;
  logic        prot_en = 1'b0;
  logic        mis_mask = 1'b0;

  logic        v_a, v_b, v_c, v_cb;
  logic [31:0] a_a, a_b, a_c, a_cb;
  logic [3:0]  f_a, f_b, f_c, f_cb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #CLK_HALF clk = ~clk;

  mem_fault_check #(.RULE_SET(0), .REGISTERED(1'b1)) dut_a_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .addr_i(addr), .mask_i(mask),
    .kind_i(kind), .prot_en_i(prot_en), .mis_mask_i(mis_mask),
    .valid_o(v_a), .addr_o(a_a), .fault_o(f_a));
  mem_fault_check #(.RULE_SET(1), .REGISTERED(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .addr_i(addr), .mask_i(mask),
    .kind_i(kind), .prot_en_i(prot_en), .mis_mask_i(mis_mask),
    .valid_o(v_b), .addr_o(a_b), .fault_o(f_b));
  mem_fault_check #(.RULE_SET(2), .REGISTERED(1'b1)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .addr_i(addr), .mask_i(mask),
    .kind_i(kind), .prot_en_i(prot_en), .mis_mask_i(mis_mask),
    .valid_o(v_c), .addr_o(a_c), .fault_o(f_c));
  mem_fault_check #(.RULE_SET(1), .REGISTERED(1'b0)) dut_comb_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .addr_i(addr), .mask_i(mask),
    .kind_i(kind), .prot_en_i(prot_en), .mis_mask_i(mis_mask),
    .valid_o(v_cb), .addr_o(a_cb), .fault_o(f_cb));

  function automatic logic inr(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // expected {flags, address} from the requirement text
  function automatic logic [35:0] model(input int rs, input logic [31:0] a, input logic [3:0] m,
                                        input logic [1:0] k, input logic pe, input logic mm);
    logic [31:0] c;
    logic mis, fm, fe, fs, fx, data, ld, er;
    logic [3:0] fl;
    c = a; fm = 0; fe = 0; fs = 0; fx = 0;
    data = (k == 2'd0) || (k == 2'd1);
    ld   = (k == 2'd0);
    mis  = (a[3:0] & m) != 4'd0;
    if (k != 2'd3) begin
      case (rs)
        0: begin
          c = a & ~{28'd0, m};
          if (data) begin
            fe = mis && !mm;
            if (m == 4'd7 && inr(c, 32'hFE800000, 32'hFEFFFFFF)) begin
              if (ld) fe = 1; else fs = 1;
            end
          end else fe = mis || inr(c, 32'hFE800000, 32'hFEFFFFFF);
        end
        1: begin
          c  = a & ~{28'd0, m};
          fm = mis;
          er = inr(c, 32'hFEFF0600, 32'hFEFF7FFF) || inr(c, 32'hFE800000, 32'hFEFEFFFF);
          if (data) begin
            if (ld) fe = er; else fs = er;
            fx = inr(c, 32'hFE000000, 32'hFE7FFFFF);
          end else begin
            fe = er;
            fx = !er && (inr(c, 32'hFE004000, 32'hFE7FFFFF) ||
                         (!pe && inr(c, 32'hFE000000, 32'hFE003FFF)));
          end
        end
        default: begin
          if (data) begin
            er = inr(a, 32'hFE800000, 32'hFEFEFFFF) || (m > 4'd3 && inr(a, 32'hFEFF0000, 32'hFEFFFFFF));
            if (ld) fe = er; else fs = er;
            fx = inr(a, 32'hFE000000, 32'hFE3FFFFF) || inr(a, 32'hFE408000, 32'hFE7FFFFF) ||
                 (!pe && inr(a, 32'hFE400000, 32'hFE407FFF));
          end else begin
            c  = a & ~{28'd0, m};
            fe = inr(c, 32'hFE800000, 32'hFEFFFFFF);
            fx = !fe && (inr(c, 32'hFE008000, 32'hFE7FFFFF) ||
                         (!pe && inr(c, 32'hFE000000, 32'hFE007FFF)));
          end
        end
      endcase
    end
    fl = fm ? 4'b0001 : fe ? 4'b0010 : fs ? 4'b0100 : fx ? 4'b1000 : 4'b0000;
    return {fl, c};
  endfunction

  task automatic cmp(input string tag, input logic v, input logic [3:0] f, input logic [31:0] ad,
                     input logic ev, input logic [35:0] exp);
    checks++;
    if (v !== ev || f !== exp[35:32] || ad !== exp[31:0]) begin
      errors++;
      $display("FAIL %s: got valid=%b flags=%b addr=%h, expected valid=%b flags=%b addr=%h (in addr=%h mask=%h kind=%0d pe=%b mm=%b)",
               tag, v, f, ad, ev, exp[35:32], exp[31:0], addr, mask, kind, prot_en, mis_mask);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [3:0] m, input logic [1:0] k,
                     input logic pe, input logic mm, input string ta, input string tb, input string tc);
    @(negedge clk);
    valid = 1'b1; addr = a; mask = m; kind = k; prot_en = pe; mis_mask = mm;
    #1;
    cmp("R12 comb", v_cb, f_cb, a_cb, 1'b1, model(1, a, m, k, pe, mm));
    @(negedge clk);
    cmp({ta, " setA"}, v_a, f_a, a_a, 1'b1, model(0, a, m, k, pe, mm));
    cmp({tb, " setB"}, v_b, f_b, a_b, 1'b1, model(1, a, m, k, pe, mm));
    cmp({tc, " setC"}, v_c, f_c, a_c, 1'b1, model(2, a, m, k, pe, mm));
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    cmp(tag, v_a, f_a, a_a, 1'b0, {4'd0, a_a});
    cmp(tag, v_b, f_b, a_b, 1'b0, {4'd0, a_b});
    cmp(tag, v_c, f_c, a_c, 1'b0, {4'd0, a_c});
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] masks [5] = '{4'd0, 4'd1, 4'd3, 4'd7, 4'd15};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R12 reset state
    cmp("R12 reset", v_a, f_a, a_a, 1'b0, 36'd0);
    cmp("R12 reset", v_b, f_b, a_b, 1'b0, 36'd0);
    cmp("R12 reset", v_c, f_c, a_c, 1'b0, 36'd0);
    @(negedge clk);
    rst_n = 1'b1;

    run(32'h0000_1000, 4'd3, 2'd0, 1'b1, 1'b0, "R2", "R2", "R2");
    run(32'hFE90_0001, 4'd7, 2'd3, 1'b0, 1'b0, "R2", "R2", "R2");
    run(32'h0000_1002, 4'd3, 2'd0, 1'b1, 1'b0, "R8", "R3", "R9");
    run(32'h0000_1002, 4'd3, 2'd1, 1'b1, 1'b1, "R8", "R3", "R9");
    run(32'hFEFF_0600, 4'd0, 2'd0, 1'b1, 1'b0, "R7", "R4 R13", "R9");
    run(32'hFEFF_7FFF, 4'd0, 2'd1, 1'b1, 1'b0, "R7", "R4 R13", "R9");
    run(32'hFEFF_0800, 4'd7, 2'd0, 1'b1, 1'b0, "R7", "R4", "R9");
    run(32'hFE80_0000, 4'd7, 2'd1, 1'b1, 1'b0, "R7 R13", "R4", "R9");
    run(32'hFE7F_FFFF, 4'd0, 2'd0, 1'b1, 1'b0, "R7", "R5 R13", "R10");
    run(32'hFE40_4000, 4'd0, 2'd1, 1'b0, 1'b0, "R7", "R5", "R10");
    run(32'hFE40_4000, 4'd0, 2'd0, 1'b1, 1'b0, "R7", "R5", "R10");
    run(32'hFE00_3FFC, 4'd3, 2'd2, 1'b0, 1'b0, "R8", "R6", "R11");
    run(32'hFE00_3FFC, 4'd3, 2'd2, 1'b1, 1'b0, "R8", "R6", "R11");
    run(32'hFE00_4000, 4'd3, 2'd2, 1'b1, 1'b0, "R8", "R6 R13", "R11");
    run(32'hFE00_8000, 4'd3, 2'd2, 1'b1, 1'b0, "R8", "R6", "R11 R13");
    run(32'hFEFF_0000, 4'd3, 2'd2, 1'b1, 1'b0, "R8", "R6", "R11");
    run(32'hFE90_0002, 4'd3, 2'd2, 1'b1, 1'b0, "R8", "R1", "R11");
    run(32'hFE80_0001, 4'd1, 2'd1, 1'b1, 1'b0, "R8", "R1", "R9");
    run(32'hFEFF_05FC, 4'd3, 2'd0, 1'b1, 1'b0, "R13", "R13", "R13");
    run(32'hFEFF_8000, 4'd0, 2'd1, 1'b1, 1'b0, "R13", "R13", "R9");
    run(32'hFDFF_FFFF, 4'd0, 2'd0, 1'b0, 1'b0, "R13", "R13", "R13");
    idle_check("R1 R12 idle");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra;
      ra = $urandom();
      if ($urandom_range(3) != 0) ra = {8'hFE, ra[23:0]};
      run(ra, masks[$urandom_range(4)], 2'($urandom_range(3)), 1'($urandom_range(1)),
          1'($urandom_range(1)), "R1", "R1", "R1");
      if (i % 500 == 0) idle_check("R12 idle");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule